// File: doc/BRIEF.md
# Current-Threshold Completion Detector

This block watches a stream of digitized supply-current samples from a single peripheral. It decides when an operation on that peripheral has finished by waiting for the current to settle back to near its idle level. The host can then continue as soon as the work is actually done, rather than waiting out the full worst-case delay. Samples are unsigned and arrive at a fixed rate, typically one million per second, each marked by a one-cycle valid strobe.

The block first learns the idle current. A calibrate request captures sixteen consecutive samples and averages them into a baseline. The threshold is that baseline plus one tenth of it, so 110 % of idle. When an operation-start pulse is accepted, the block counts samples from the start. Samples that fall inside a programmable minimum-latency window are disregarded. After the window, the block needs four consecutive samples below the threshold before it raises a one-cycle completion pulse. A programmable worst-case sample count acts as a timeout. If it runs out first, completion is forced and a timeout flag is raised.

The minimum latency and the worst-case count must be held stable while an operation is being tracked.

Top module: `curr_done_detect`

## Requirements
- R1: After reset, `done_pulse` is 0, `timeout` is 0 and `thresh` is 0.
- R2: A `cal_req` accepted while idle captures the next 16 valid samples. Their sum is divided by 16 and rounded down to give the baseline B. One clock after the 16th sample, `thresh` becomes B + floor(B/10). `thresh` does not change at any other time.
- R3: A sample counts as below only when its value is strictly less than `thresh`. A sample equal to `thresh` is not below.
- R4: Valid samples are numbered from 0, starting with the first valid sample after the accepted start. A sample whose number is less than `min_lat` never contributes to completion.
- R5: Completion needs 4 consecutive eligible below samples. Any eligible sample that is not below restarts the count.
- R6: `done_pulse` is high for exactly one clock: the clock after the edge that captured the completing sample.
- R7: If the sample numbered `max_cnt`-1 or later is captured without completing, `done_pulse` pulses and `timeout` rises. `timeout` stays high until the next accepted start clears it. If a quiet completion and the timeout fall on the same sample, the quiet completion wins and `timeout` stays 0.
- R8: An `op_start` is ignored in three cases: while a calibration is running, in the same cycle as a `cal_req`, or while an operation is already being tracked. In the last case the sample numbering is not restarted.
- R9: A `cal_req` that arrives while an operation is tracked is ignored, and `thresh` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Current sample strobe |
| smp_data | input | SAMPLE_W | Unsigned current sample |
| cal_req | input | 1 | Begin idle-current calibration |
| op_start | input | 1 | Operation-start pulse |
| min_lat | input | LAT_W | Minimum-latency window in samples |
| max_cnt | input | TMO_W | Worst-case sample count before timeout |
| done_pulse | output | 1 | One-cycle completion indication |
| thresh | output | SAMPLE_W+1 | Learned completion threshold |
| timeout | output | 1 | Completion was forced by the worst-case count |

## Verification
The assertions check several properties on every cycle:
- the completion pulse never lasts two cycles (R6);
- a rising timeout always comes with the completion pulse (R7);
- the threshold never moves outside a running calibration (R2);
- a tracked operation never starts while calibrating (R8);
- a quiet completion never occurs before the minimum-latency window plus four samples (R4);
- the consecutive-sample counter stays in range (R5).

Only the bench's scenarios can show the remaining behaviour:
- the numeric threshold value after averaging;
- the strictness of the below comparison at equality;
- the exact sample on which completion lands;
- the reset of the quiet count by a noise glitch;
- the priority of quiet completion over a simultaneous timeout;
- that start and calibrate requests are really discarded.

// File: rtl/cdd_pkg.sv
package cdd_pkg;
  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_BUSY = 1'b1
  } trk_state_e;
endpackage

// File: rtl/cdd_calib.sv
module cdd_calib #(
  parameter int SAMPLE_W = 12,
  parameter int CAL_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_go,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                cal_active,
  output logic [SAMPLE_W:0]   thresh
);
  localparam int CAL_N = 1 << CAL_LOG2;
  localparam int ACC_W = SAMPLE_W + CAL_LOG2;

  logic                active_q, active_d;
  logic [CAL_LOG2-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0]    acc_q, acc_d;
  logic [SAMPLE_W:0]   thr_q, thr_d;
  logic                take, last;
  logic [ACC_W-1:0]    sum_full;
  logic [SAMPLE_W:0]   base_ext, thr_calc;

  always_comb begin
    take     = active_q && smp_vld;
    last     = take && (cnt_q == CAL_LOG2'(CAL_N - 1));
    sum_full = acc_q + ACC_W'(smp_data);
    base_ext = {1'b0, sum_full[ACC_W-1:CAL_LOG2]};
    thr_calc = base_ext + (base_ext / (SAMPLE_W+1)'(10));

    active_d = active_q;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    thr_d    = thr_q;
    if (!active_q && cal_go) begin
      active_d = 1'b1;
      cnt_d    = '0;
      acc_d    = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = sum_full;
      if (last) begin
        active_d = 1'b0;
        thr_d    = thr_calc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
      thr_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      acc_q    <= acc_d;
      thr_q    <= thr_d;
    end
  end

  assign cal_active = active_q;
  assign thresh     = thr_q;

  AST_THRESH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> $stable(thr_q)); // R2
endmodule

// File: rtl/cdd_quiet.sv
module cdd_quiet #(
  parameter int QUIET_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic qualify,
  output logic hit
);
  localparam int QW = $clog2(QUIET_N + 1);

  logic [QW-1:0] cnt_q, cnt_d;

  always_comb begin
    hit   = step && qualify && (cnt_q == QW'(QUIET_N - 1));
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = (qualify && !hit) ? cnt_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_QUIET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < QW'(QUIET_N)); // R5
endmodule

// File: rtl/cdd_tracker.sv
module cdd_tracker
  import cdd_pkg::*;
#(
  parameter int LAT_W   = 16,
  parameter int TMO_W   = 20,
  parameter int QUIET_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic             cal_busy,
  input  logic             cal_req,
  input  logic             smp_vld,
  input  logic [LAT_W-1:0] min_lat,
  input  logic [TMO_W-1:0] max_cnt,
  input  logic             quiet_hit,
  output logic             trk_idle,
  output logic             step,
  output logic             eligible,
  output logic             q_clr,
  output logic             done_pulse,
  output logic             timeout
);
  localparam int CW = ((LAT_W > TMO_W) ? LAT_W : TMO_W) + 2;

  trk_state_e       state_q, state_d;
  logic [TMO_W-1:0] elapsed_q, elapsed_d;
  logic             done_q, done_d;
  logic             tmo_q, tmo_d;
  logic             accept, expire, finish;

  always_comb begin
    accept   = (state_q == TRK_IDLE) && op_start && !cal_busy && !cal_req;
    step     = (state_q == TRK_BUSY) && smp_vld;
    eligible = CW'(elapsed_q) >= CW'(min_lat);
    expire   = step && !quiet_hit && ((CW'(elapsed_q) + CW'(1)) >= CW'(max_cnt));
    finish   = step && (quiet_hit || expire);

    state_d   = state_q;
    elapsed_d = elapsed_q;
    tmo_d     = tmo_q;
    done_d    = finish;
    if (accept) begin
      state_d   = TRK_BUSY;
      elapsed_d = '0;
      tmo_d     = 1'b0;
    end else if (step) begin
      elapsed_d = elapsed_q + 1'b1;
      if (finish) state_d = TRK_IDLE;
      if (expire) tmo_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TRK_IDLE;
      elapsed_q <= '0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      elapsed_q <= elapsed_d;
      done_q    <= done_d;
      tmo_q     <= tmo_d;
    end
  end

  assign trk_idle   = (state_q == TRK_IDLE);
  assign q_clr      = accept;
  assign done_pulse = done_q;
  assign timeout    = tmo_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> done_q); // R7
  AST_CAL_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TRK_IDLE && cal_busy) |=> state_q == TRK_IDLE); // R8
  AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_hit |-> CW'(elapsed_q) >= CW'(min_lat) + CW'(QUIET_N - 1)); // R4
endmodule

// File: rtl/curr_done_detect.sv
module curr_done_detect #(
  parameter int SAMPLE_W = 12,
  parameter int CAL_LOG2 = 4,
  parameter int QUIET_N  = 4,
  parameter int LAT_W    = 16,
  parameter int TMO_W    = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                cal_req,
  input  logic                op_start,
  input  logic [LAT_W-1:0]    min_lat,
  input  logic [TMO_W-1:0]    max_cnt,
  output logic                done_pulse,
  output logic [SAMPLE_W:0]   thresh,
  output logic                timeout
);
  logic cal_active, trk_idle, step, eligible, q_clr, quiet_hit;
  logic below, cal_go;

  assign cal_go = cal_req && trk_idle;
  assign below  = {1'b0, smp_data} < thresh;

  cdd_calib #(.SAMPLE_W(SAMPLE_W), .CAL_LOG2(CAL_LOG2)) u_calib (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_go     (cal_go),
    .smp_vld    (smp_vld),
    .smp_data   (smp_data),
    .cal_active (cal_active),
    .thresh     (thresh)
  );

  cdd_quiet #(.QUIET_N(QUIET_N)) u_quiet (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (q_clr),
    .step    (step),
    .qualify (below && eligible),
    .hit     (quiet_hit)
  );

  cdd_tracker #(.LAT_W(LAT_W), .TMO_W(TMO_W), .QUIET_N(QUIET_N)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_start   (op_start),
    .cal_busy   (cal_active),
    .cal_req    (cal_req),
    .smp_vld    (smp_vld),
    .min_lat    (min_lat),
    .max_cnt    (max_cnt),
    .quiet_hit  (quiet_hit),
    .trk_idle   (trk_idle),
    .step       (step),
    .eligible   (eligible),
    .q_clr      (q_clr),
    .done_pulse (done_pulse),
    .timeout    (timeout)
  );
endmodule

// File: tb/test_curr_done_detect.sv
module test_curr_done_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [11:0] smp_data = '0;
  logic        cal_req = 1'b0;
  logic        op_start = 1'b0;
  logic [15:0] min_lat = '0;
  logic [19:0] max_cnt = 20'd1000;
  logic        done_pulse, timeout;
  logic [12:0] thresh;

  int checks = 0;
  int failures = 0;
  logic done_seen;

  always #10 clk = ~clk;

  curr_done_detect i_curr_done_detect (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .cal_req(cal_req), .op_start(op_start), .min_lat(min_lat), .max_cnt(max_cnt),
    .done_pulse(done_pulse), .thresh(thresh), .timeout(timeout)
  );

  typedef struct packed {
    int idle; int minl; int maxc; int hi; int nhi; int lo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{100,  5, 1000, 300,  3, 105},
    '{100,  0,   40, 300,  2, 110},
    '{200,  0, 1000, 500, 10, 219},
    '{999, 20, 1000, 3000, 2,   0},
    '{ 50,  2,    6,  90,  1,  10},
    '{4095, 3, 1000, 4095, 0, 4095}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int val);
    @(negedge clk); smp_vld = 1'b1; smp_data = 12'(val);
    @(negedge clk); smp_vld = 1'b0;
    done_seen = done_pulse;
  endtask

  task automatic pulse_start();
    @(negedge clk); op_start = 1'b1;
    @(negedge clk); op_start = 1'b0;
  endtask

  task automatic calibrate_const(input int val);
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    for (int i = 0; i < 16; i++) send(val);
  endtask

  task automatic model(input vec_t v, output int k_exp, output bit tmo_exp);
    int thr, q, val;
    thr = v.idle + v.idle / 10;
    q = 0; k_exp = -1; tmo_exp = 0;
    for (int k = 0; k < 2048; k++) begin
      val = (k < v.nhi) ? v.hi : v.lo;
      if (k >= v.minl && val < thr) q++; else q = 0;
      if (q == 4) begin k_exp = k; break; end
      if (k + 1 >= v.maxc) begin k_exp = k; tmo_exp = 1; break; end
    end
  endtask

  task automatic run_ops(input int first_k, input int total, input int hi, input int nhi,
                         input int lo, output int k_got);
    k_got = -1;
    for (int k = first_k; k < total; k++) begin
      send((k < nhi) ? hi : lo);
      if (done_seen) begin k_got = k; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int kg, ke;
    bit te;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(done_pulse == 1'b0, "R1 done", int'(done_pulse), 0);
    check(timeout == 1'b0, "R1 timeout", int'(timeout), 0);
    check(thresh == 13'd0, "R1 thresh", int'(thresh), 0);
    rst_n = 1'b1;

    // Table of scenarios: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      calibrate_const(TBL[i].idle);
      @(negedge clk);
      check(int'(thresh) == TBL[i].idle + TBL[i].idle / 10, "R2 table thresh",
            int'(thresh), TBL[i].idle + TBL[i].idle / 10);
      min_lat = 16'(TBL[i].minl);
      max_cnt = 20'(TBL[i].maxc);
      model(TBL[i], ke, te);
      pulse_start();
      run_ops(0, 2048, TBL[i].hi, TBL[i].nhi, TBL[i].lo, kg);
      check(kg == ke, "R3/R4/R5 table done index", kg, ke);
      check(timeout == te, "R7 table timeout", int'(timeout), int'(te));
      @(negedge clk);
      check(done_pulse == 1'b0, "R6 single pulse", int'(done_pulse), 0);
    end

    // R2 averaging with varying samples: sum 1200 -> base 75 -> thresh 82
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    for (int i = 0; i < 16; i++) send(i * 10);
    @(negedge clk);
    check(thresh == 13'd82, "R2 average floor", int'(thresh), 82);

    // R5 glitch restarts the quiet count
    min_lat = 16'd0; max_cnt = 20'd1000;
    pulse_start();
    kg = -1;
    for (int k = 0; k < 12; k++) begin
      send((k == 3) ? 90 : 50);
      if (done_seen) begin kg = k; break; end
    end
    check(kg == 7, "R5 glitch", kg, 7);

    // R8 start during calibration ignored
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    send(100);
    pulse_start();
    for (int i = 0; i < 15; i++) send(100);
    kg = -1;
    for (int k = 0; k < 8; k++) begin
      send(0);
      if (done_seen) kg = k;
    end
    check(kg == -1, "R8 start in cal", kg, -1);
    check(thresh == 13'd110, "R2 thresh 110", int'(thresh), 110);

    // R8 second start while tracking does not restart numbering
    min_lat = 16'd4;
    pulse_start();
    for (int k = 0; k < 3; k++) send(150);
    pulse_start();
    run_ops(3, 40, 150, 3, 50, kg);
    check(kg == 7, "R8 start while tracking", kg, 7);

    // R9 cal_req while tracking ignored; R7 timeout hold and clear
    min_lat = 16'd0; max_cnt = 20'd10;
    pulse_start();
    send(500); send(500);
    @(negedge clk); cal_req = 1'b1;
    @(negedge clk); cal_req = 1'b0;
    run_ops(2, 40, 500, 40, 0, kg);
    check(kg == 9, "R7 timeout index", kg, 9);
    check(thresh == 13'd110, "R9 thresh kept", int'(thresh), 110);
    repeat (5) @(negedge clk);
    check(timeout == 1'b1, "R7 timeout held", int'(timeout), 1);
    max_cnt = 20'd1000;
    pulse_start();
    check(timeout == 1'b0, "R7 timeout cleared", int'(timeout), 0);
    run_ops(0, 20, 0, 0, 0, kg);
    check(kg == 3, "R3 clear op", kg, 3);

    // R8 cal_req and op_start together: calibration wins
    @(negedge clk); cal_req = 1'b1; op_start = 1'b1;
    @(negedge clk); cal_req = 1'b0; op_start = 1'b0;
    for (int i = 0; i < 16; i++) send(200);
    @(negedge clk);
    check(thresh == 13'd220, "R2 thresh 220", int'(thresh), 220);
    kg = -1;
    for (int k = 0; k < 8; k++) begin
      send(0);
      if (done_seen) kg = k;
    end
    check(kg == -1, "R8 simultaneous start", kg, -1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule